// File: doc/BRIEF.md
# Byte-Writable Flow-Through SRAM Bank

This block is one bank of a 72-bit synchronous static memory. On each rising clock edge it captures a word address, a set of write qualifiers and the write data from an upstream sequencer. If the bank is selected, writes go into the array at that same edge (early write). Reads are flow-through: the word at the captured address shows on the output during the cycle after the edge, with no second register stage.

Each 72-bit word holds eight data bytes in bits 63:0 and eight parity bits in bits 71:64. Byte lane k is data bits 8k+7:8k together with parity bit 64+k. A global write strobe stores the whole word. Otherwise a byte-mode enable gates eight per-lane strobes.

The bank is chosen by a group of four active-low bank enables. An asynchronous active-low output enable and an asynchronous active-high snooze input can both switch the read driver off at any time. High impedance is shown by `q_drv` low, and `q_out` is then all zeros.

Top module: `sram72_bank`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `q_drv` is 0 and `q_out` is 0.
- R2: A selected, non-snoozed edge with `gw_n`=0 writes all 72 bits of `wdata` to `addr`, whatever `bwe_n` and `bw_n` are.
- R3: With `gw_n`=1 and `bwe_n`=0, each lane k whose `bw_n[k]`=0 stores `wdata[8k+7:8k]` and `wdata[64+k]`. Lanes whose strobe is 1 keep their old contents.
- R4: With `gw_n`=1 and `bwe_n`=1, the lane strobes have no effect: nothing is written, and the cycle is a read.
- R5: A read cycle captured at an edge drives the stored word at the captured address on `q_out` with `q_drv`=1 before the next edge, provided `oe_n`=0 and `snooze`=0.
- R6: The bank is selected only when `bank_en_n[BANK_ID]`=0 and the other three bits are 1. Any other pattern writes nothing and leaves `q_drv`=0 in the next cycle.
- R7: `oe_n`=1 forces `q_drv` to 0 at once, with no clock edge. Returning it to 0 restores a pending read.
- R8: In the cycle after a write edge, `q_drv` is 0 even though `oe_n` is 0.
- R9: `snooze`=1 forces `q_drv` to 0 at once and blocks writes at any edge where it is high. Array contents are retained.
- R10: Whenever `q_drv` is 0, `q_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the cycle state |
| addr | input | AW (4) | Word address |
| bank_en_n | input | NBANKS (4) | Active-low bank enables |
| gw_n | input | 1 | Active-low global write |
| bwe_n | input | 1 | Active-low byte-write mode enable |
| bw_n | input | NBYTES (8) | Active-low per-lane write strobes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Asynchronous active-high standby |
| wdata | input | 72 | Write word: data in 63:0, parity in 71:64 |
| q_out | output | 72 | Read word, zero when not driving |
| q_drv | output | 1 | 1 when the read driver is on |

## Verification
A corrupted lane mask shows up on the first later read of that address, one cycle after its edge. The symptom is one byte plus one parity bit that is stale, or changed when it should not have been. Wrong captured select or write state shows on `q_drv` in the very next cycle, as a driver that is on during a write or on a deselected edge, or off for a valid read. The asynchronous gating is probed between edges, so a gate that wrongly waits for the clock is exposed within a fraction of a cycle.

// File: rtl/sram72_bank.sv
module sram72_bank #(
  parameter int DEPTH   = 16,
  parameter int NBYTES  = 8,
  parameter int NBANKS  = 4,
  parameter int BANK_ID = 0,
  localparam int AW     = $clog2(DEPTH),
  localparam int DW     = NBYTES * 8,
  localparam int WIDTH  = NBYTES * 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [NBANKS-1:0] bank_en_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  q_out,
  output logic              q_drv
);
  localparam logic [NBANKS-1:0] SEL_PAT = ~(NBANKS'(1) << BANK_ID);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [NBYTES-1:0] lane_we;
  logic [WIDTH-1:0]  wmask;
  logic              act_now, wr_now;
  logic              act_r, wr_r;
  logic [AW-1:0]     addr_r;

  assign act_now = (bank_en_n == SEL_PAT) && !snooze;
  assign lane_we = {NBYTES{!gw_n}} | ({NBYTES{!bwe_n}} & ~bw_n);
  assign wr_now  = |lane_we;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign wmask[8*k +: 8] = {8{lane_we[k]}};
    assign wmask[DW + k]   = lane_we[k];
  end

  always_ff @(posedge clk) begin
    if (act_now && wr_now)
      mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_r  <= 1'b0;
      wr_r   <= 1'b0;
      addr_r <= '0;
    end else begin
      act_r  <= act_now;
      wr_r   <= wr_now;
      addr_r <= addr;
    end
  end

  assign q_drv = act_r && !wr_r && !oe_n && !snooze;
  assign q_out = q_drv ? mem[addr_r] : '0;
endmodule

// File: rtl/sram72_bank_chk.sv
module sram72_bank_chk #(
  parameter int NBYTES  = 8,
  parameter int NBANKS  = 4,
  parameter int BANK_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NBANKS-1:0] bank_en_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [NBYTES-1:0] bw_n,
  input logic              oe_n,
  input logic              snooze,
  input logic              q_drv
);
  logic picked, is_wr, rd_pend;
  assign picked = bank_en_n == ~(NBANKS'(1) << BANK_ID);
  assign is_wr  = !gw_n || (!bwe_n && !(&bw_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= picked && !snooze && !is_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!q_drv);
  end

  a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !oe_n && !snooze) |-> q_drv);
  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !picked |=> !q_drv);
  a_r7_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !q_drv);
  a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && is_wr) |=> !q_drv);
  a_r9_snooze_gates: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !q_drv);
endmodule

bind sram72_bank sram72_bank_chk #(.NBYTES(NBYTES), .NBANKS(NBANKS), .BANK_ID(BANK_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .bank_en_n(bank_en_n), .gw_n(gw_n), .bwe_n(bwe_n),
  .bw_n(bw_n), .oe_n(oe_n), .snooze(snooze), .q_drv(q_drv)
);

// File: tb/sram72_bank_tb.sv
module sram72_bank_tb_top;
  localparam int BID = 2;
  localparam logic [3:0] SEL = 4'b1011;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0, bank_en_n = 4'hF;
  logic gw_n = 1, bwe_n = 1, oe_n = 0, snooze = 0;
  logic [7:0] bw_n = 8'hFF;
  logic [71:0] wdata = 0, q_out;
  logic q_drv;
  int total = 0, bad = 0;

  logic [71:0] mdl [16];
  logic lact = 0, lwr = 0;
  logic [3:0] laddr = 0;

  always #2 clk = ~clk;

  sram72_bank #(.DEPTH(16), .BANK_ID(BID)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bank_en_n(bank_en_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .snooze(snooze), .wdata(wdata),
    .q_out(q_out), .q_drv(q_drv));

  function automatic logic [71:0] lane_mask(logic g, logic b, logic [7:0] s);
    logic [71:0] m = '0;
    for (int k = 0; k < 8; k++) begin
      logic on = !g || (!b && !s[k]);
      m[8*k +: 8] = {8{on}};
      m[64 + k] = on;
    end
    return m;
  endfunction

  function automatic logic exp_drv();
    return lact && !lwr && !oe_n && !snooze;
  endfunction

  task automatic chk(string req);
    logic ed = exp_drv();
    logic [71:0] eq = ed ? mdl[laddr] : 72'h0;
    total++;
    if (q_drv !== ed || q_out !== eq) begin
      bad++;
      $display("FAIL %s: drv=%0b q=%h expected drv=%0b q=%h", req, q_drv, q_out, ed, eq);
    end
  endtask

  task automatic cyc(input logic [3:0] be, input logic g, input logic b,
                     input logic [7:0] s, input logic o, input logic z,
                     input logic [3:0] a, input logic [71:0] d);
    logic [71:0] m;
    logic act;
    @(negedge clk);
    bank_en_n = be; gw_n = g; bwe_n = b; bw_n = s; oe_n = o; snooze = z; addr = a; wdata = d;
    @(posedge clk);
    m = lane_mask(g, b, s);
    act = (be == SEL) && !z && rst_n;
    if (act && |m) mdl[a] = (mdl[a] & ~m) | (d & m);
    lact = act; lwr = |m; laddr = a;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    cyc(SEL, 1, 1, 8'hFF, 0, 0, a, 72'h0);
    chk(req);
  endtask

  function automatic logic [71:0] rnd72();
    return {$urandom() & 8'hFF, $urandom(), $urandom()};
  endfunction

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: drv=%0b q=%h expected completion", q_drv, q_out);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (2) @(posedge clk);
    #1 chk("R1 in reset");
    @(negedge clk) rst_n = 1;
    @(posedge clk) #1 chk("R1 first cycle");

    for (int i = 0; i < 16; i++) cyc(SEL, 0, 1, 8'hFF, 0, 0, 4'(i), rnd72());
    rd(4'd3, "R2 fill readback");

    cyc(SEL, 0, 1, 8'h00, 0, 0, 4'd5, 72'hA5_0123456789ABCDEF);
    chk("R8 write cycle no drive");
    rd(4'd5, "R2 global write all bits");

    cyc(SEL, 1, 0, 8'b1010_0101, 0, 0, 4'd5, 72'h5A_FEDCBA9876543210);
    rd(4'd5, "R3 lane write with parity");

    cyc(SEL, 1, 1, 8'h00, 0, 0, 4'd5, 72'hFF_FFFFFFFFFFFFFFFF);
    chk("R4 mode enable high reads");
    rd(4'd5, "R4 no change");

    cyc(4'b0011, 0, 1, 8'h00, 0, 0, 4'd6, 72'h0);
    chk("R6 two enables no drive");
    cyc(4'hF, 1, 1, 8'hFF, 0, 0, 4'd6, 72'h0);
    chk("R6 all high no drive");
    rd(4'd6, "R6 contents kept");

    rd(4'd7, "R5 flow-through read");
    oe_n = 1; #1 chk("R7 oe off async");
    oe_n = 0; #1 chk("R7 oe back on");
    snooze = 1; #1 chk("R9 snooze off async");
    if (q_out !== 72'h0) begin bad++; $display("FAIL R10: q=%h expected 0", q_out); end
    total++;
    snooze = 0; #1 chk("R9 snooze release");

    cyc(SEL, 0, 1, 8'h00, 0, 1, 4'd7, 72'h0);
    chk("R9 snoozed write");
    rd(4'd7, "R9 retained");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] be = ($urandom() % 4 == 0) ? 4'($urandom()) : SEL;
      logic [7:0] s = ($urandom() % 3 == 0) ? 8'hFF : 8'($urandom());
      cyc(be, ($urandom() % 5) != 0, $urandom() % 2 == 1, s, ($urandom() % 6) == 0,
          ($urandom() % 16) == 0, 4'($urandom()), rnd72());
      chk("R5 random mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule